// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when each row of a dynamic memory array must be refreshed, and which row comes next. A free-running interval counter produces one refresh demand per row period. A row counter names the next row to refresh. A request line stays high toward the memory controller while any demand is outstanding. Each cycle in which the controller acknowledges a raised request counts as one refreshed row, and the row counter then steps forward. The sequence of refresh commands and the timing of the memory pins belong to the controller.

Two policies share the counters and the handshake. In the spread policy there is one demand per row period, so one row is refreshed every window length divided by row count. With 4096 rows and a 64 ms window that period is about 15.6 µs. In the block policy there is one demand per full window, and the request stays high until every remaining row has been refreshed back to back. The total refresh work is the same, but it arrives as one contiguous stretch. Demands that arrive while the controller is slow are counted, so none is lost. If the backlog reaches a set limit, a sticky flag reports it.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low, and on the first cycle after it, `req`, `row_addr`, `window_done` and `overflow` are all zero, and the interval and demand counters are cleared.
- R2: When `burst_mode` is 0, one demand arises every `INTERVAL` clock cycles. After reset is released, `req` first goes high just after the `INTERVAL`-th rising edge.
- R3: `req` is high exactly while the count of outstanding demands is nonzero. It stays high through cycles in which `ack` is low.
- R4: A cycle with `req` and `ack` both high is one completed row refresh. `row_addr` then increments by one, and it wraps from `ROWS-1` to 0.
- R5: `ack` while `req` is low is ignored: `row_addr` and the outstanding count do not change.
- R6: `window_done` is high for exactly the one cycle after the row `ROWS-1` is acknowledged, which is the cycle in which `row_addr` reads 0 again.
- R7: The outstanding count saturates at `MAX_PEND`. A demand that arrives while the count is full, with no completion in the same cycle, sets `overflow`. `overflow` then stays high until reset.
- R8: When `burst_mode` is 1, one demand arises every `INTERVAL*ROWS` cycles, and none arise in between. That demand keeps `req` high across back-to-back acknowledgements until the row `ROWS-1` has been acknowledged.
- R9: If a new demand and a completion fall in the same cycle, the outstanding count is unchanged, so `req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 0 = one row per row period, 1 = all rows once per window |
| ack | input | 1 | Controller reports the requested row refreshed |
| req | output | 1 | Refresh request to the controller |
| row_addr | output | clog2(ROWS) | Row to refresh next |
| window_done | output | 1 | One-cycle pulse when the row counter wraps to 0 |
| overflow | output | 1 | Sticky flag: a demand was dropped at full backlog |

## Verification
The bench builds the block with 8 rows, a 5-cycle row period and a backlog limit of 3. At these values a whole window is 40 cycles, so the bench reaches row wrap, block-policy windows and backlog saturation many times within a few thousand cycles. The small limit makes the overflow edge a short directed sequence. The coincidence of a new demand with a completion, and switches of policy while a backlog is outstanding, come up often under random acknowledgement.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROWS     = 4096,
  parameter int INTERVAL = 1560,
  parameter int MAX_PEND = 8,
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_mode,
  input  logic             ack,
  output logic             req,
  output logic [ROW_W-1:0] row_addr,
  output logic             window_done,
  output logic             overflow
);
  localparam int IC_W = $clog2(INTERVAL + 1);
  localparam int PD_W = $clog2(MAX_PEND + 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [IC_W-1:0]  LAST_IC  = IC_W'(INTERVAL - 1);
  localparam logic [PD_W-1:0]  FULL     = PD_W'(MAX_PEND);

  logic [IC_W-1:0]  ic;
  logic [ROW_W-1:0] tc;
  logic [PD_W-1:0]  pend;

  logic tick, wtick, served, at_last, dem, fin;

  assign tick    = ic == LAST_IC;
  assign wtick   = tick && (tc == LAST_ROW);
  assign req     = pend != '0;
  assign served  = ack && req;
  assign at_last = row_addr == LAST_ROW;
  assign dem     = burst_mode ? wtick : tick;
  assign fin     = served && (!burst_mode || at_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ic          <= '0;
      tc          <= '0;
      pend        <= '0;
      row_addr    <= '0;
      window_done <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      ic <= tick ? '0 : ic + 1'b1;
      if (tick) tc <= (tc == LAST_ROW) ? '0 : tc + 1'b1;
      if (served) row_addr <= at_last ? '0 : row_addr + 1'b1;
      window_done <= served && at_last;
      if (dem && !fin) begin
        if (pend == FULL) overflow <= 1'b1;
        else              pend <= pend + 1'b1;
      end else if (fin && !dem) begin
        pend <= pend - 1'b1;
      end
    end
  end
endmodule

module dram_refresh_sched_chk #(
  parameter int ROWS  = 4096,
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             req,
  input logic [ROW_W-1:0] row_addr,
  input logic             window_done,
  input logic             overflow
);
  // R5
  ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && ack) |=> $stable(row_addr));
  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> (($past(row_addr) == ROW_W'(ROWS - 1)) ? (row_addr == '0)
                                                            : (row_addr == $past(row_addr) + 1'b1)));
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  // R6
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |-> (row_addr == '0));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .req(req), .row_addr(row_addr),
  .window_done(window_done), .overflow(overflow));

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int CLK_P = 10;
  localparam int ROWS = 8, INTERVAL = 5, MAX_PEND = 3;
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 0, rst_n = 0, burst_mode = 0, ack = 0;
  logic req, window_done, overflow;
  logic [ROW_W-1:0] row_addr;
  int total = 0, bad = 0;

  // model state: what the outputs should read after the last edge
  int m_ic, m_tc, m_pend, m_row, m_wd, m_ovf;

  always #(CLK_P/2) clk = ~clk;

  dram_refresh_sched #(.ROWS(ROWS), .INTERVAL(INTERVAL), .MAX_PEND(MAX_PEND)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .ack(ack),
    .req(req), .row_addr(row_addr), .window_done(window_done), .overflow(overflow));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int wrap_inc(input int v, input int n);
    return (v == n - 1) ? 0 : v + 1;
  endfunction

  task automatic model_reset();
    m_ic = 0; m_tc = 0; m_pend = 0; m_row = 0; m_wd = 0; m_ovf = 0;
  endtask

  task automatic model_step(input bit bm, input bit a);
    bit tick, wtick, served, lst, dem, fin;
    tick   = (m_ic == INTERVAL - 1);
    wtick  = tick && (m_tc == ROWS - 1);
    served = a && (m_pend != 0);
    lst    = (m_row == ROWS - 1);
    dem    = bm ? wtick : tick;
    fin    = served && (!bm || lst);
    m_ic = wrap_inc(m_ic, INTERVAL);
    if (tick) m_tc = wrap_inc(m_tc, ROWS);
    if (served) m_row = wrap_inc(m_row, ROWS);
    m_wd = served && lst;
    if (dem && !fin) begin
      if (m_pend == MAX_PEND) m_ovf = 1; else m_pend++;
    end else if (fin && !dem) m_pend--;
  endtask

  task automatic compare_all();
    chk("R3 req", int'(req), int'(m_pend != 0));
    chk("R4 row_addr", int'(row_addr), m_row);
    chk("R6 window_done", int'(window_done), m_wd);
    chk("R7 overflow", int'(overflow), m_ovf);
  endtask

  task automatic step(input bit bm, input bit a);
    burst_mode = bm; ack = a;
    model_step(bm, a);
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 0; ack = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 req", int'(req), 0);
    chk("R1 row_addr", int'(row_addr), 0);
    chk("R1 window_done", int'(window_done), 0);
    chk("R1 overflow", int'(overflow), 0);
    model_reset();
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    // R5: ack while idle leaves row untouched
    step(0, 1);
    chk("R5 row after idle ack", int'(row_addr), 0);
    // R2: first demand after INTERVAL edges
    repeat (INTERVAL - 2) step(0, 0);
    chk("R2 req before period", int'(req), 0);
    step(0, 0);
    chk("R2 req at period", int'(req), 1);
    // R7: backlog saturates then overflows
    repeat (MAX_PEND * INTERVAL - 1) step(0, 0);
    chk("R7 overflow before", int'(overflow), 0);
    step(0, 0);
    chk("R7 overflow set", int'(overflow), 1);
    repeat (3) step(0, 1);
    chk("R7 overflow sticky", int'(overflow), 1);

    // R9: demand and completion together
    do_reset();
    repeat (INTERVAL) step(0, 0);
    repeat (INTERVAL - 1) step(0, 0);
    step(0, 1);
    chk("R9 req kept", int'(req), 1);
    chk("R9 row", int'(row_addr), 1);
    step(0, 1);
    chk("R9 req cleared", int'(req), 0);

    // R8: block policy, no demand before a full window
    do_reset();
    begin
      int seen = 0;
      for (int i = 0; i < ROWS * INTERVAL - 1; i++) begin
        step(1, 1);
        if (req) seen++;
      end
      chk("R8 no req mid window", seen, 0);
    end
    step(1, 0);
    chk("R8 req at window", int'(req), 1);
    for (int r = 0; r < ROWS - 1; r++) begin
      step(1, 1);
      chk("R8 req held in block", int'(req), 1);
    end
    step(1, 1);
    chk("R8 req done", int'(req), 0);
    chk("R6 pulse on wrap", int'(window_done), 1);
    chk("R4 row wrapped", int'(row_addr), 0);
    step(1, 0);
    chk("R6 pulse single", int'(window_done), 0);

    // random phases, both policies
    do_reset();
    for (int ph = 0; ph < 16; ph++) begin
      bit bm = ph[0];
      int dens = 1 + ($urandom % 4);
      for (int i = 0; i < 200; i++) step(bm, ($urandom % 4) < dens);
    end
    finish_run();
  end
endmodule